// File: doc/BRIEF.md
# Display-Fetch Memory Select and Pixel Loader

This block sits beside a Z80-style CPU in a small home computer. It decodes the two top address bits together with the memory-request strobe into active-low ROM and RAM selects, one of each. It also follows the display-file execution flag. While that flag is set, an opcode fetch returns a NOP to the CPU, and the block keeps the real byte on the data bus as the character code.

The next refresh cycle brings the graphic byte onto the bus. If that byte comes from ROM, the ROM select stays asserted after the memory request ends, all the way to the end of T4. This lets the pixel shift register take the bus at the first T1 sample of the next machine cycle. The register then shifts pixels out most significant bit first, one per pixel enable.

All inputs are sampled on a single system clock. A T-state input (0 = T1, 1 = T2, 2 = T3, 3 = T4) and a half flag (0 = first half, 1 = second half) give the bus phase.

Top module: `vfm_top`

## Requirements
- R1: On each clock, a ROM-region address (upper bits 00) with memory request low drives rom_cs_n low after that edge. Any other upper-bit value with memory request low drives ram_cs_n low. Selects are registered, with one clock of latency.
- R2: rom_cs_n and ram_cs_n are never low in the same cycle.
- R3: In ordinary fetches, reads and refresh cycles, a select goes high at the first edge that samples memory request high.
- R4: A forced fetch is a sample with nop_force=1, mreq_n=0, rd_n=0 and rfsh_n=1. If the refresh that follows it addresses ROM, rom_cs_n stays low on every T4 sample, including after memory request rises. It goes high at the first T1 sample.
- R5: If the refresh after a forced fetch addresses RAM, ram_cs_n follows memory request and nothing is stretched.
- R6: The data bus is captured into char_code at the second-half T2 sample of a forced fetch.
- R7: At the first T1 sample after a refresh that followed a forced fetch, the data bus loads the shift register. Its MSB appears on pix_out right after that edge. A pixel enable in the same cycle is ignored.
- R8: Each pix_en shifts one pixel, MSB first. After 8 shifts, and before any load, pix_out is 0.
- R9: Synchronous reset drives both selects high, clears the pending stretch and load, and sets pix_out and char_code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 2 | Upper two address bits |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| tstate | input | 2 | Bus T-state, 0..3 = T1..T4 |
| thalf | input | 1 | 0 first half, 1 second half |
| nop_force | input | 1 | Display-file execution flag |
| data_in | input | 8 | Data bus |
| pix_en | input | 1 | Pixel clock enable |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| char_code | output | 8 | Captured character code |
| pix_out | output | 1 | Serial pixel |

## Verification
Two actions can fall on the same edge. The shift-register load at the first T1 after a display refresh can coincide with a pixel enable, and the release of the stretched ROM select can coincide with a RAM fetch starting. The vector table raises pix_en on the load edge itself, and places a RAM-region fetch directly after a stretched ROM refresh. The bench then checks three things: pix_out shows the new MSB rather than a shifted bit, rom_cs_n rises on that same edge, and ram_cs_n falls one sample later without ever overlapping rom_cs_n.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  typedef enum logic [1:0] {
    TS_T1 = 2'd0,
    TS_T2 = 2'd1,
    TS_T3 = 2'd2,
    TS_T4 = 2'd3
  } tstate_e;

  typedef struct packed {
    logic mem_act;    // memory request asserted
    logic rom_area;   // upper address bits select ROM
    logic op_fetch;   // read with refresh inactive
    logic refresh;    // refresh with memory request
  } bus_cyc_t;
endpackage

// File: rtl/vfm_decode.sv
module vfm_decode #(
  parameter int HI_BITS = 2
) (
  input  logic [HI_BITS-1:0] addr_hi,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               rfsh_n,
  output vfm_pkg::bus_cyc_t  cyc
);
  logic area_zero;

  generate
    if (HI_BITS == 1) begin : g_one
      assign area_zero = ~addr_hi[0];
    end else begin : g_many
      assign area_zero = ~|addr_hi;
    end
  endgenerate

  always_comb begin
    cyc.mem_act  = ~mreq_n;
    cyc.rom_area = area_zero;
    cyc.op_fetch = ~mreq_n & ~rd_n & rfsh_n;
    cyc.refresh  = ~mreq_n & ~rfsh_n;
  end
endmodule

// File: rtl/vfm_sequencer.sv
module vfm_sequencer #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  vfm_pkg::bus_cyc_t cyc,
  input  logic [1:0]        tstate,
  input  logic              thalf,
  input  logic              nop_force,
  input  logic [DW-1:0]     data_in,
  output logic              load_now,
  output logic              stretch_hold,
  output logic [DW-1:0]     char_code
);
  import vfm_pkg::*;

  logic nop_pend;     // forced fetch seen, refresh not yet
  logic disp_rfsh;    // refresh of a display fetch in progress
  logic stretch_rom;  // that refresh addressed ROM
  logic forced_hit;
  logic cap_now;

  assign forced_hit   = cyc.op_fetch & nop_force;
  assign cap_now      = forced_hit & (tstate_e'(tstate) == TS_T2) & thalf;
  assign load_now     = disp_rfsh & (tstate_e'(tstate) == TS_T1);
  assign stretch_hold = disp_rfsh & stretch_rom & (tstate_e'(tstate) == TS_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_pend    <= 1'b0;
      disp_rfsh   <= 1'b0;
      stretch_rom <= 1'b0;
    end else begin
      if (cyc.op_fetch) begin
        nop_pend <= nop_force;
      end else if (cyc.refresh && nop_pend) begin
        nop_pend    <= 1'b0;
        disp_rfsh   <= 1'b1;
        stretch_rom <= cyc.rom_area;
      end
      if (load_now) begin
        disp_rfsh   <= 1'b0;
        stretch_rom <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      char_code <= '0;
    end else if (cap_now) begin
      char_code <= data_in;
    end
  end

  // R6
  char_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap_now |=> char_code == $past(data_in));

  // R4
  stretch_rom_only_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_hold |-> !cyc.op_fetch);
endmodule

// File: rtl/vfm_select.sv
module vfm_select (
  input  logic              clk,
  input  logic              rst,
  input  vfm_pkg::bus_cyc_t cyc,
  input  logic              stretch_hold,
  output logic              rom_cs_n,
  output logic              ram_cs_n
);
  logic rom_hit;
  logic ram_hit;

  assign rom_hit = cyc.mem_act & cyc.rom_area;
  assign ram_hit = cyc.mem_act & ~cyc.rom_area & ~stretch_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n <= 1'b1;
      ram_cs_n <= 1'b1;
    end else begin
      rom_cs_n <= ~(rom_hit | stretch_hold);
      ram_cs_n <= ~ram_hit;
    end
  end

  // R2
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rom_cs_n && !ram_cs_n));

  // R4
  rom_stretch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!rom_cs_n && !$past(rom_hit)) |-> $past(stretch_hold));

  // R3
  ram_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc.mem_act |=> ram_cs_n);
endmodule

// File: rtl/vfm_pixshift.sv
module vfm_pixshift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_now,
  input  logic [DW-1:0] data_in,
  input  logic          pix_en,
  output logic          pix_out
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [DW-1:0] shreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (load_now) begin
      shreg <= data_in;
      left  <= FULL;
    end else if (pix_en && left != '0) begin
      shreg <= {shreg[DW-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  assign pix_out = (left != '0) & shreg[DW-1];

  // R7
  load_first_pix_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> pix_out == $past(data_in[DW-1]));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    left <= FULL);

  // R8
  blank_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (left == '0) |-> !pix_out);
endmodule

// File: rtl/vfm_top.sv
module vfm_top #(
  parameter int HI_BITS = 2,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HI_BITS-1:0] addr_hi,
  input  logic               mreq_n,
  input  logic               rd_n,
  input  logic               rfsh_n,
  input  logic [1:0]         tstate,
  input  logic               thalf,
  input  logic               nop_force,
  input  logic [DW-1:0]      data_in,
  input  logic               pix_en,
  output logic               rom_cs_n,
  output logic               ram_cs_n,
  output logic [DW-1:0]      char_code,
  output logic               pix_out
);
  vfm_pkg::bus_cyc_t cyc;
  logic load_now;
  logic stretch_hold;

  vfm_decode #(.HI_BITS(HI_BITS)) u_decode (
    .addr_hi (addr_hi),
    .mreq_n  (mreq_n),
    .rd_n    (rd_n),
    .rfsh_n  (rfsh_n),
    .cyc     (cyc)
  );

  vfm_sequencer #(.DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cyc          (cyc),
    .tstate       (tstate),
    .thalf        (thalf),
    .nop_force    (nop_force),
    .data_in      (data_in),
    .load_now     (load_now),
    .stretch_hold (stretch_hold),
    .char_code    (char_code)
  );

  vfm_select u_select (
    .clk          (clk),
    .rst          (rst),
    .cyc          (cyc),
    .stretch_hold (stretch_hold),
    .rom_cs_n     (rom_cs_n),
    .ram_cs_n     (ram_cs_n)
  );

  vfm_pixshift #(.DW(DW)) u_pix (
    .clk      (clk),
    .rst      (rst),
    .load_now (load_now),
    .data_in  (data_in),
    .pix_en   (pix_en),
    .pix_out  (pix_out)
  );
endmodule

// File: tb/vfm_top_bench.sv
module vfm_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr_hi = '0;
  logic mreq_n = 1'b1, rd_n = 1'b1, rfsh_n = 1'b1;
  logic [1:0] tstate = '0;
  logic thalf = 1'b0, nop_force = 1'b0, pix_en = 1'b0;
  logic [7:0] data_in = '0;
  logic rom_cs_n, ram_cs_n, pix_out;
  logic [7:0] char_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vfm_top u_vfm_top (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .mreq_n(mreq_n), .rd_n(rd_n),
    .rfsh_n(rfsh_n), .tstate(tstate), .thalf(thalf), .nop_force(nop_force),
    .data_in(data_in), .pix_en(pix_en), .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n), .char_code(char_code), .pix_out(pix_out)
  );

  // row: t,h,mreq_n,rd_n,rfsh_n,nop,hi,data,pix_en | exp rom_n,ram_n,pix
  function automatic logic [20:0] v(int t, int h, int mq, int rd, int rf,
      int nf, int hi, int d, int pe, int er, int em, int ep);
    return {2'(t), 1'(h), 1'(mq), 1'(rd), 1'(rf), 1'(nf), 2'(hi), 8'(d),
            1'(pe), 1'(er), 1'(em), 1'(ep)};
  endfunction

  localparam int NV = 39;
  localparam logic [20:0] VEC [NV] = '{
    // ordinary ROM fetch and refresh: R1 R3
    v(0,0,1,1,1,0,0,8'h00,0, 1,1,0), v(0,1,0,0,1,0,0,8'h00,0, 0,1,0),
    v(1,0,0,0,1,0,0,8'h00,0, 0,1,0), v(1,1,0,0,1,0,0,8'h00,0, 0,1,0),
    v(2,0,0,1,0,0,0,8'h00,0, 0,1,0), v(2,1,0,1,0,0,0,8'h00,0, 0,1,0),
    v(3,0,0,1,0,0,0,8'h00,0, 0,1,0), v(3,1,1,1,0,0,0,8'h00,0, 1,1,0),
    // forced fetch, ROM refresh, stretch: R4 R6
    v(0,0,1,1,1,1,0,8'h00,0, 1,1,0), v(0,1,0,0,1,1,0,8'h2A,0, 0,1,0),
    v(1,0,0,0,1,1,0,8'h2A,0, 0,1,0), v(1,1,0,0,1,1,0,8'h2A,0, 0,1,0),
    v(2,0,0,1,0,1,0,8'hB5,0, 0,1,0), v(2,1,0,1,0,1,0,8'hB5,0, 0,1,0),
    v(3,0,0,1,0,1,0,8'hB5,0, 0,1,0), v(3,1,1,1,0,1,0,8'hB5,0, 0,1,0),
    // load with pix_en, RAM fetch, shifting: R7 R8 R2
    v(0,0,1,1,1,0,1,8'hB5,1, 1,1,1), v(0,1,0,0,1,0,1,8'h00,1, 1,0,0),
    v(1,0,0,0,1,0,1,8'h00,1, 1,0,1), v(1,1,0,0,1,0,1,8'h00,1, 1,0,1),
    v(2,0,0,1,0,0,1,8'h00,1, 1,0,0), v(2,1,0,1,0,0,1,8'h00,1, 1,0,1),
    v(3,0,0,1,0,0,1,8'h00,1, 1,0,0), v(3,1,1,1,0,0,1,8'h00,1, 1,1,1),
    v(0,0,1,1,1,0,0,8'h00,1, 1,1,0), v(0,0,1,1,1,0,0,8'h00,1, 1,1,0),
    // forced fetch in RAM, RAM refresh, no stretch: R5
    v(0,0,1,1,1,1,3,8'h00,0, 1,1,0), v(0,1,0,0,1,1,3,8'h11,0, 1,0,0),
    v(1,0,0,0,1,1,3,8'h11,0, 1,0,0), v(1,1,0,0,1,1,3,8'h11,0, 1,0,0),
    v(2,0,0,1,0,1,2,8'h0F,0, 1,0,0), v(2,1,0,1,0,1,2,8'h0F,0, 1,0,0),
    v(3,0,0,1,0,1,2,8'h0F,0, 1,0,0), v(3,1,1,1,0,1,2,8'h0F,0, 1,1,0),
    v(0,0,1,1,1,0,0,8'h0F,0, 1,1,0), v(0,0,1,1,1,0,0,8'h00,1, 1,1,0),
    v(0,0,1,1,1,0,0,8'h00,1, 1,1,0), v(0,0,1,1,1,0,0,8'h00,1, 1,1,0),
    v(0,0,1,1,1,0,0,8'h00,1, 1,1,1)
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [20:0] r);
    @(negedge clk);
    tstate = r[20:19]; thalf = r[18]; mreq_n = r[17]; rd_n = r[16];
    rfsh_n = r[15]; nop_force = r[14]; addr_hi = r[13:12];
    data_in = r[11:4]; pix_en = r[3];
    @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R9 reset state
    chk("R9 rom", {7'd0, rom_cs_n}, 8'd1);
    chk("R9 ram", {7'd0, ram_cs_n}, 8'd1);
    chk("R9 pix", {7'd0, pix_out}, 8'd0);
    chk("R9 char", char_code, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk("R1/R3/R4/R5 rom_cs_n", {7'd0, rom_cs_n}, {7'd0, VEC[i][2]});
      chk("R1/R2/R5 ram_cs_n", {7'd0, ram_cs_n}, {7'd0, VEC[i][1]});
      chk("R7/R8 pix_out", {7'd0, pix_out}, {7'd0, VEC[i][0]});
      if (i == 15) chk("R6 char after rom fetch", char_code, 8'h2A);
    end
    chk("R6 char after ram fetch", char_code, 8'h11);

    // R9: reset during a stretched refresh
    for (int i = 8; i < 15; i++) apply(VEC[i]);
    @(negedge clk);
    rst = 1'b1;
    apply(VEC[15]);
    chk("R9 rom released by reset", {7'd0, rom_cs_n}, 8'd1);
    chk("R9 char cleared", char_code, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    apply(v(0,0,1,1,1,0,0,8'hFF,1, 1,1,0));
    chk("R9 no load after reset", {7'd0, pix_out}, 8'd0);
    chk("R9 rom stays high", {7'd0, rom_cs_n}, 8'd1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule